// File: doc/BRIEF.md
# SMBus Block Transfer Buffer Engine

This engine sits between the host register port of an SMBus controller and a small message buffer of DEPTH bytes (32 by default). It handles block-data transfers and works in one of two modes, picked by the `auxBlk` input. In buffered mode, software streams every byte of a message through the block-data port into the buffer before a write, or out of the buffer after a read. In byte-handshake mode, the buffer is stepped one byte at a time. Each byte is exchanged through a single block-data register, and software acknowledges it by writing the status register.

The engine keeps the buffer index, the byte count, an internal operation-done flag and the status flags busy, interrupt, byte-done, device-error and failed. The transaction sequencer tells the engine when a block operation starts (`startBlk`) and gives the returned length for reads. It fills the buffer from the bus through a side write port and reads it back through a side read port. When the engine pulses `commitWr`, the sequencer carries out the bus write of `count` bytes.

Only one access strobe is presented in any cycle. If several are asserted together, the priority is: kill, start, status write, block-data write, block-data read, count write, then bus-side write.

Top module: `smb_blkbuf_engine`

## Requirements
- R1: After reset, busy, intr, byteDone, devErr, failed, commitWr, bufIdx, count and blkData are all zero, and the engine is idle (operation done).
- R2: In buffered mode (auxBlk=1), a block-data write stores blkWrData at the current index and then increments the index. If the index has reached DEPTH before the access, it first wraps to 0, so the 33rd byte lands in entry 0 and leaves bufIdx at 1.
- R3: In buffered mode, a block-data read returns the buffer byte at the current index and then increments the index. While an operation is active, the read that brings the index up to count completes it: bufIdx returns to 0 and busy clears.
- R4: A buffered-mode write start (startBlk with isRead=0) behaves as follows. If bufIdx differs from count, it sets devErr and zeroes bufIdx without committing. Otherwise it pulses commitWr for one cycle, sets intr, clears busy and zeroes bufIdx.
- R5: A buffered-mode read start (isRead=1) loads count from rdLen, sets intr and busy, and zeroes bufIdx.
- R6: A byte-mode start (auxBlk=0) sets busy and byteDone and zeroes bufIdx. For a write, the block-data register is copied into buffer entry 0. For a read, count is loaded from rdLen and buffer entry 0 is presented on blkData.
- R7: In byte mode during an active write, each status write advances the index (wrapping at DEPTH). If the new index differs from count, the block-data register is stored at that index and byteDone is set. If it equals count, commitWr pulses, intr is set and busy clears.
- R8: In byte mode during an active read, each status write advances the index and presents the buffer byte at the new index on blkData. With lastByte=0 it also sets byteDone. With lastByte=1 it completes the operation: intr is set, busy clears and bufIdx returns to 0.
- R9: If protoI2cRd=1 when a byte-mode write reaches its count, the engine sets devErr instead of committing, and busy stays set.
- R10: A status write while the engine is idle, or while auxBlk=1, changes neither bufIdx, blkData nor the buffer.
- R11: kill sets failed, clears busy and returns the engine to idle with bufIdx at 0.
- R12: A status write clears the flags named in stsClr: bit 0 intr, bit 1 byteDone, bit 2 devErr, bit 3 failed. A flag that the same status write sets stays set.
- R13: cntWr loads count from cntData. count changes only on cntWr or on a read start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| auxBlk | input | 1 | 1 = buffered mode, 0 = byte-handshake mode |
| isRead | input | 1 | Direction of the current transfer (1 = read) |
| protoI2cRd | input | 1 | The selected protocol is the I2C block read |
| lastByte | input | 1 | Last-byte control for byte-mode reads |
| startBlk | input | 1 | Start of a block operation, from the sequencer |
| rdLen | input | CW | Returned length, captured on a read start |
| kill | input | 1 | Abort of the current operation |
| stsWr | input | 1 | Software write to the status register |
| stsClr | input | 4 | Write-one-to-clear mask of the status write |
| blkWr | input | 1 | Software write to the block-data port |
| blkWrData | input | DW | Data of the block-data write |
| blkRd | input | 1 | Software read of the block-data port |
| blkRdData | output | DW | Data returned by the block-data read (combinational) |
| cntWr | input | 1 | Software write of the byte count |
| cntData | input | CW | New byte count |
| busWrEn | input | 1 | Bus-side buffer write enable |
| busWrIdx | input | AW | Bus-side write index |
| busWrData | input | DW | Bus-side write data |
| busRdIdx | input | AW | Bus-side read index |
| busRdData | output | DW | Buffer byte at busRdIdx |
| commitWr | output | 1 | One-cycle pulse: perform the bus write of count bytes |
| count | output | CW | Byte count |
| bufIdx | output | IW | Current buffer index (0 to DEPTH) |
| busy | output | 1 | Operation in progress |
| intr | output | 1 | Completion flag |
| byteDone | output | 1 | Byte handshake flag |
| devErr | output | 1 | Device error flag |
| failed | output | 1 | Operation killed |
| blkData | output | DW | Block-data register |

## Verification
The assertions assume that at most one of kill, startBlk, stsWr, blkWr, blkRd and cntWr is high in any cycle, and that each is a single-cycle strobe. They also assume that bus-side writes never coincide with a software access. Under these assumptions, the index arithmetic and the flag effects checked one cycle later are unambiguous. The stimulus drives every access from its own task, which raises exactly one strobe for one cycle and drops it before the next access. The bus-side fills happen only while software is quiet.

// File: rtl/smbbuf_pkg.sv
package smbbuf_pkg;

  // strobes from the control to the buffer datapath
  typedef struct packed {
    logic bufWrPort;   // write blkWrData into the buffer at the target index
    logic bufWrBlk;    // write the block-data register into the buffer
    logic blkFromPort; // load the block-data register from blkWrData
    logic blkFromBuf;  // load the block-data register from the buffer
  } bufStrobe_t;

  // bit positions inside the status clear mask
  localparam int CLR_INTR  = 0;
  localparam int CLR_BYTE  = 1;
  localparam int CLR_DERR  = 2;
  localparam int CLR_FAIL  = 3;
  localparam int CLR_W     = 4;

endpackage

// File: rtl/smb_blkbuf_ctrl.sv
module smb_blkbuf_ctrl
  import smbbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              auxBlk,
  input  logic              isRead,
  input  logic              protoI2cRd,
  input  logic              lastByte,
  input  logic              startBlk,
  input  logic [CW-1:0]     rdLen,
  input  logic              kill,
  input  logic              stsWr,
  input  logic [CLR_W-1:0]  stsClr,
  input  logic              blkWr,
  input  logic              blkRd,
  input  logic              cntWr,
  input  logic [CW-1:0]     cntData,
  output bufStrobe_t        strb,
  output logic [AW-1:0]     tgtAddr,
  output logic              commitWr,
  output logic [CW-1:0]     count,
  output logic [IW-1:0]     bufIdx,
  output logic              busy,
  output logic              intr,
  output logic              byteDone,
  output logic              devErr,
  output logic              failed
);

  logic          opDone;
  logic [IW-1:0] idxWrap, idxInc, idxAdv, idxPost;
  logic [IW-1:0] nIdx;
  logic [CW-1:0] nCount;
  logic          nOpDone, nBusy, nIntr, nByte, nDerr, nFail, nCommit;

  function automatic logic hitCount(input logic [IW-1:0] ix, input logic [CW-1:0] cnt);
    return 32'(ix) == 32'(cnt);
  endfunction

  // index as used by a port access: wraps to zero once it has reached DEPTH
  assign idxWrap = (32'(bufIdx) >= DEPTH) ? '0 : bufIdx;
  assign idxPost = idxWrap + IW'(1);
  // index after a handshake step: increment, then wrap
  assign idxInc  = bufIdx + IW'(1);
  assign idxAdv  = (32'(idxInc) >= DEPTH) ? '0 : idxInc;

  always_comb begin
    nIdx    = bufIdx;
    nCount  = count;
    nOpDone = opDone;
    nBusy   = busy;
    nIntr   = intr;
    nByte   = byteDone;
    nDerr   = devErr;
    nFail   = failed;
    nCommit = 1'b0;
    strb    = '0;
    tgtAddr = idxWrap[AW-1:0];

    if (kill) begin
      nOpDone = 1'b1;
      nIdx    = '0;
      nFail   = 1'b1;
      nBusy   = 1'b0;
    end else if (startBlk) begin
      if (auxBlk) begin
        nIdx = '0;
        if (isRead) begin
          nOpDone = 1'b0;
          nIntr   = 1'b1;
          nBusy   = 1'b1;
          nCount  = rdLen;
        end else if (!hitCount(bufIdx, count)) begin
          nDerr = 1'b1;
        end else begin
          nCommit = 1'b1;
          nOpDone = 1'b1;
          nIntr   = 1'b1;
          nBusy   = 1'b0;
        end
      end else begin
        nOpDone = 1'b0;
        nBusy   = 1'b1;
        nByte   = 1'b1;
        nIdx    = '0;
        tgtAddr = '0;
        if (isRead) begin
          nCount          = rdLen;
          strb.blkFromBuf = 1'b1;
        end else begin
          strb.bufWrBlk = 1'b1;
        end
      end
    end else if (stsWr) begin
      if (stsClr[CLR_INTR]) nIntr = 1'b0;
      if (stsClr[CLR_BYTE]) nByte = 1'b0;
      if (stsClr[CLR_DERR]) nDerr = 1'b0;
      if (stsClr[CLR_FAIL]) nFail = 1'b0;
      if (!opDone && !auxBlk) begin
        nIdx    = idxAdv;
        tgtAddr = idxAdv[AW-1:0];
        if (!isRead) begin
          if (hitCount(idxAdv, count)) begin
            if (protoI2cRd) begin
              nDerr = 1'b1;
            end else begin
              nCommit = 1'b1;
              nOpDone = 1'b1;
              nIntr   = 1'b1;
              nBusy   = 1'b0;
            end
          end else begin
            strb.bufWrBlk = 1'b1;
            nByte         = 1'b1;
          end
        end else begin
          strb.blkFromBuf = 1'b1;
          if (lastByte) begin
            nOpDone = 1'b1;
            nIdx    = '0;
            nIntr   = 1'b1;
            nBusy   = 1'b0;
          end else begin
            nByte = 1'b1;
          end
        end
      end
    end else if (blkWr) begin
      if (auxBlk) begin
        strb.bufWrPort = 1'b1;
        nIdx           = idxPost;
      end else begin
        strb.blkFromPort = 1'b1;
      end
    end else if (blkRd) begin
      if (auxBlk) begin
        nIdx = idxPost;
        if (!opDone && hitCount(idxPost, count)) begin
          nOpDone = 1'b1;
          nIdx    = '0;
          nBusy   = 1'b0;
        end
      end
    end else if (cntWr) begin
      nCount = cntData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufIdx   <= '0;
      count    <= '0;
      opDone   <= 1'b1;
      busy     <= 1'b0;
      intr     <= 1'b0;
      byteDone <= 1'b0;
      devErr   <= 1'b0;
      failed   <= 1'b0;
      commitWr <= 1'b0;
    end else begin
      bufIdx   <= nIdx;
      count    <= nCount;
      opDone   <= nOpDone;
      busy     <= nBusy;
      intr     <= nIntr;
      byteDone <= nByte;
      devErr   <= nDerr;
      failed   <= nFail;
      commitWr <= nCommit;
    end
  end

endmodule

// File: rtl/smb_blkbuf_data.sv
module smb_blkbuf_data
  import smbbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  bufStrobe_t    strb,
  input  logic [AW-1:0] tgtAddr,
  input  logic [DW-1:0] portData,
  input  logic          busWrEn,
  input  logic [AW-1:0] busWrIdx,
  input  logic [DW-1:0] busWrData,
  input  logic [AW-1:0] busRdIdx,
  output logic [DW-1:0] tgtData,
  output logic [DW-1:0] busRdData,
  output logic [DW-1:0] blkReg
);

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] weVec;
  logic [DW-1:0]    wData;
  logic             ctlWe;

  assign ctlWe = strb.bufWrPort | strb.bufWrBlk;
  assign wData = strb.bufWrPort ? portData :
                 strb.bufWrBlk  ? blkReg   : busWrData;

  // per-entry write decode: the control side wins over the bus side
  for (genvar g = 0; g < DEPTH; g++) begin : gDec
    assign weVec[g] = ctlWe ? (tgtAddr == AW'(g)) : (busWrEn && (busWrIdx == AW'(g)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (weVec[i]) mem[i] <= wData;
      end
    end
  end

  assign tgtData   = mem[tgtAddr];
  assign busRdData = mem[busRdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                blkReg <= '0;
    else if (strb.blkFromPort) blkReg <= portData;
    else if (strb.blkFromBuf)  blkReg <= tgtData;
  end

endmodule

// File: rtl/smb_blkbuf_engine.sv
module smb_blkbuf_engine
  import smbbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int CW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             auxBlk,
  input  logic             isRead,
  input  logic             protoI2cRd,
  input  logic             lastByte,
  input  logic             startBlk,
  input  logic [CW-1:0]    rdLen,
  input  logic             kill,
  input  logic             stsWr,
  input  logic [CLR_W-1:0] stsClr,
  input  logic             blkWr,
  input  logic [DW-1:0]    blkWrData,
  input  logic             blkRd,
  output logic [DW-1:0]    blkRdData,
  input  logic             cntWr,
  input  logic [CW-1:0]    cntData,
  input  logic             busWrEn,
  input  logic [AW-1:0]    busWrIdx,
  input  logic [DW-1:0]    busWrData,
  input  logic [AW-1:0]    busRdIdx,
  output logic [DW-1:0]    busRdData,
  output logic             commitWr,
  output logic [CW-1:0]    count,
  output logic [IW-1:0]    bufIdx,
  output logic             busy,
  output logic             intr,
  output logic             byteDone,
  output logic             devErr,
  output logic             failed,
  output logic [DW-1:0]    blkData
);

  bufStrobe_t    strb;
  logic [AW-1:0] tgtAddr;
  logic [DW-1:0] tgtData;

  smb_blkbuf_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .auxBlk(auxBlk), .isRead(isRead),
    .protoI2cRd(protoI2cRd), .lastByte(lastByte), .startBlk(startBlk),
    .rdLen(rdLen), .kill(kill), .stsWr(stsWr), .stsClr(stsClr),
    .blkWr(blkWr), .blkRd(blkRd), .cntWr(cntWr), .cntData(cntData),
    .strb(strb), .tgtAddr(tgtAddr), .commitWr(commitWr), .count(count),
    .bufIdx(bufIdx), .busy(busy), .intr(intr), .byteDone(byteDone),
    .devErr(devErr), .failed(failed)
  );

  smb_blkbuf_data #(.DEPTH(DEPTH), .DW(DW)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .tgtAddr(tgtAddr),
    .portData(blkWrData), .busWrEn(busWrEn), .busWrIdx(busWrIdx),
    .busWrData(busWrData), .busRdIdx(busRdIdx), .tgtData(tgtData),
    .busRdData(busRdData), .blkReg(blkData)
  );

  assign blkRdData = auxBlk ? tgtData : blkData;

endmodule

// File: rtl/smb_blkbuf_engine_chk.sv
module smb_blkbuf_engine_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = AW + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          auxBlk,
  input logic          kill,
  input logic          startBlk,
  input logic          stsWr,
  input logic [3:0]    stsClr,
  input logic          blkWr,
  input logic          blkRd,
  input logic          cntWr,
  input logic          commitWr,
  input logic [CW-1:0] count,
  input logic [IW-1:0] bufIdx,
  input logic          busy,
  input logic          intr,
  input logic          byteDone,
  input logic          failed
);

  // input assumption: one access strobe per cycle
  p_one_access: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({kill, startBlk, stsWr, blkWr, blkRd, cntWr}));

  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    32'(bufIdx) <= DEPTH);

  p_port_write_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (blkWr && auxBlk && 32'(bufIdx) < DEPTH)
      |=> 32'(bufIdx) == 32'($past(bufIdx)) + 1);

  p_commit_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    commitWr |-> (intr && !busy));

  p_byte_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (startBlk && !auxBlk) |=> (busy && byteDone && bufIdx == '0));

  p_kill_r11: assert property (@(posedge clk) disable iff (!rstN)
    kill |=> (failed && !busy && bufIdx == '0));

  p_fail_held_r12: assert property (@(posedge clk) disable iff (!rstN)
    (failed && !(stsWr && stsClr[3])) |=> failed);

  p_count_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWr && !startBlk) |=> $stable(count));

endmodule

bind smb_blkbuf_engine smb_blkbuf_engine_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .auxBlk(auxBlk), .kill(kill), .startBlk(startBlk),
  .stsWr(stsWr), .stsClr(stsClr), .blkWr(blkWr), .blkRd(blkRd),
  .cntWr(cntWr), .commitWr(commitWr), .count(count), .bufIdx(bufIdx),
  .busy(busy), .intr(intr), .byteDone(byteDone), .failed(failed)
);

// File: tb/smb_blkbuf_engine_tb.sv
`timescale 1ns/1ps
module smb_blkbuf_engine_tb;

  localparam int DEPTH = 32;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int AW = $clog2(DEPTH);
  localparam int IW = AW + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic auxBlk = 0, isRead = 0, protoI2cRd = 0, lastByte = 0;
  logic startBlk = 0, kill = 0, stsWr = 0, blkWr = 0, blkRd = 0, cntWr = 0;
  logic busWrEn = 0;
  logic [CW-1:0] rdLen = '0, cntData = '0, count;
  logic [3:0] stsClr = '0;
  logic [DW-1:0] blkWrData = '0, blkRdData, busWrData = '0, busRdData, blkData;
  logic [AW-1:0] busWrIdx = '0, busRdIdx = '0;
  logic commitWr, busy, intr, byteDone, devErr, failed;
  logic [IW-1:0] bufIdx;

  int nChk = 0;
  int nErr = 0;
  bit doneFlag = 0;

  always #2 clk = ~clk;

  smb_blkbuf_engine #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rstN(rstN), .auxBlk(auxBlk), .isRead(isRead),
    .protoI2cRd(protoI2cRd), .lastByte(lastByte), .startBlk(startBlk),
    .rdLen(rdLen), .kill(kill), .stsWr(stsWr), .stsClr(stsClr),
    .blkWr(blkWr), .blkWrData(blkWrData), .blkRd(blkRd), .blkRdData(blkRdData),
    .cntWr(cntWr), .cntData(cntData), .busWrEn(busWrEn), .busWrIdx(busWrIdx),
    .busWrData(busWrData), .busRdIdx(busRdIdx), .busRdData(busRdData),
    .commitWr(commitWr), .count(count), .bufIdx(bufIdx), .busy(busy),
    .intr(intr), .byteDone(byteDone), .devErr(devErr), .failed(failed),
    .blkData(blkData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doStart(input logic rd, input int len);
    isRead = rd; rdLen = CW'(len); startBlk = 1; tick(); startBlk = 0;
  endtask
  task automatic doSts(input logic [3:0] clr);
    stsClr = clr; stsWr = 1; tick(); stsWr = 0; stsClr = '0;
  endtask
  task automatic doBlkWr(input logic [DW-1:0] d);
    blkWrData = d; blkWr = 1; tick(); blkWr = 0;
  endtask
  task automatic doBlkRd(output logic [DW-1:0] d);
    blkRd = 1; #1 d = blkRdData; tick(); blkRd = 0;
  endtask
  task automatic doCnt(input int n);
    cntData = CW'(n); cntWr = 1; tick(); cntWr = 0;
  endtask
  task automatic doKill();
    kill = 1; tick(); kill = 0;
  endtask
  task automatic doBusWr(input int i, input logic [DW-1:0] d);
    busWrIdx = AW'(i); busWrData = d; busWrEn = 1; tick(); busWrEn = 0;
  endtask
  task automatic peek(input int i, output logic [DW-1:0] d);
    busRdIdx = AW'(i); #1 d = busRdData;
  endtask

  function automatic logic [DW-1:0] patA(input int n, input int k);
    return DW'(n * 7 + k * 13 + 1);
  endfunction
  function automatic logic [DW-1:0] patB(input int n, input int k);
    return DW'(n * 29 + k * 5 + 3);
  endfunction

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  CHECKS %0d ERRORS %0d", nChk, nErr);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin : main
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    chk("R1 flags", {busy, intr, byteDone, devErr, failed, commitWr}, 0);
    chk("R1 idx", bufIdx, 0);
    chk("R1 count", count, 0);
    chk("R1 blkData", blkData, 0);

    // R10: status write while idle in byte mode has no effect
    auxBlk = 0;
    doSts(4'h0);
    chk("R10 idle idx", bufIdx, 0);
    chk("R10 idle byteDone", byteDone, 0);
    chk("R10 idle blkData", blkData, 0);

    // R2/R4/R13: buffered write sweep
    auxBlk = 1;
    for (int n = 1; n <= DEPTH; n++) begin
      for (int k = 0; k < n; k++) doBlkWr(patA(n, k));
      chk("R2 fill idx", bufIdx, n);
      doCnt(n);
      chk("R13 count", count, n);
      doStart(0, 0);
      chk("R4 commit", commitWr, 1);
      chk("R4 intr", intr, 1);
      chk("R4 busy", busy, 0);
      chk("R4 idx", bufIdx, 0);
      chk("R4 no err", devErr, 0);
      tick();
      chk("R4 pulse", commitWr, 0);
      for (int k = 0; k < n; k++) begin
        peek(k, d);
        chk("R2 content", d, patA(n, k));
      end
      doSts(4'h1);
      chk("R12 intr clear", intr, 0);
      chk("R10 buffered idx", bufIdx, 0);
    end

    // R2 wrap and R4 mismatch
    for (int k = 0; k < DEPTH; k++) doBlkWr(patA(0, k));
    chk("R2 full idx", bufIdx, DEPTH);
    doBlkWr(8'hA5);
    chk("R2 wrap idx", bufIdx, 1);
    peek(0, d);
    chk("R2 wrap data", d, 8'hA5);
    doCnt(DEPTH);
    doStart(0, 0);
    chk("R4 mismatch err", devErr, 1);
    chk("R4 mismatch idx", bufIdx, 0);
    chk("R4 mismatch nocommit", commitWr, 0);
    doSts(4'h4);
    chk("R12 devErr clear", devErr, 0);

    // R5/R3: buffered read sweep
    for (int n = 1; n <= DEPTH; n++) begin
      for (int k = 0; k < DEPTH; k++) doBusWr(k, patB(n, k));
      doStart(1, n);
      chk("R5 count", count, n);
      chk("R5 intr", intr, 1);
      chk("R5 busy", busy, 1);
      chk("R5 idx", bufIdx, 0);
      doSts(4'h1);
      for (int k = 0; k < n; k++) begin
        doBlkRd(d);
        chk("R3 data", d, patB(n, k));
        if (k < n - 1) begin
          chk("R3 busy mid", busy, 1);
          chk("R3 idx mid", bufIdx, k + 1);
        end
      end
      chk("R3 done busy", busy, 0);
      chk("R3 done idx", bufIdx, 0);
    end
    // idle read just steps the index
    doBlkRd(d);
    chk("R3 idle data", d, patB(DEPTH, 0));
    chk("R3 idle idx", bufIdx, 1);
    chk("R3 idle busy", busy, 0);

    // R6/R7: byte-mode write sweep
    auxBlk = 0;
    protoI2cRd = 0;
    for (int n = 1; n < DEPTH; n++) begin
      doCnt(n);
      doBlkWr(patA(n + 40, 0));
      chk("R6 blk load", blkData, patA(n + 40, 0));
      doStart(0, 0);
      chk("R6 busy", busy, 1);
      chk("R6 byteDone", byteDone, 1);
      chk("R6 idx", bufIdx, 0);
      peek(0, d);
      chk("R6 first byte", d, patA(n + 40, 0));
      for (int k = 1; k < n; k++) begin
        doBlkWr(patA(n + 40, k));
        doSts(4'h2);
        chk("R7 step idx", bufIdx, k);
        chk("R7 step byteDone", byteDone, 1);
        peek(k, d);
        chk("R7 stored", d, patA(n + 40, k));
      end
      doSts(4'h2);
      chk("R7 commit", commitWr, 1);
      chk("R7 intr", intr, 1);
      chk("R7 busy", busy, 0);
      chk("R7 idx", bufIdx, n);
      doSts(4'h3);
      chk("R10 after commit idx", bufIdx, n);
    end

    // R6/R8/R11: byte-mode read sweep
    for (int n = 1; n < DEPTH; n++) begin
      for (int k = 0; k < DEPTH; k++) doBusWr(k, patB(n + 50, k));
      lastByte = 0;
      doStart(1, n);
      chk("R6 read count", count, n);
      chk("R6 read blk", blkData, patB(n + 50, 0));
      chk("R6 read busy", busy, 1);
      for (int k = 1; k < n; k++) begin
        lastByte = (k == n - 1);
        doSts(4'h2);
        chk("R8 blk", blkData, patB(n + 50, k));
        if (k == n - 1) begin
          chk("R8 last intr", intr, 1);
          chk("R8 last busy", busy, 0);
          chk("R8 last idx", bufIdx, 0);
        end else begin
          chk("R8 byteDone", byteDone, 1);
          chk("R8 idx", bufIdx, k);
        end
      end
      lastByte = 0;
      doKill();
      chk("R11 failed", failed, 1);
      chk("R11 busy", busy, 0);
      chk("R11 idx", bufIdx, 0);
      d = blkData;
      doSts(4'hF);
      chk("R12 fail clear", failed, 0);
      chk("R10 killed idx", bufIdx, 0);
      chk("R10 killed blk", blkData, d);
    end

    // R9: I2C block read protocol reaching count in byte write
    protoI2cRd = 1;
    doCnt(2);
    doBlkWr(8'h11);
    doStart(0, 0);
    doBlkWr(8'h22);
    doSts(4'h0);
    chk("R9 step idx", bufIdx, 1);
    doSts(4'h0);
    chk("R9 devErr", devErr, 1);
    chk("R9 nocommit", commitWr, 0);
    chk("R9 busy", busy, 1);
    // R12: set wins over clear in the same write
    doBlkWr(8'h33);
    doKill();
    protoI2cRd = 0;
    doSts(4'hF);
    doCnt(3);
    doBlkWr(8'h44);
    doStart(0, 0);
    doBlkWr(8'h55);
    doSts(4'h2);
    chk("R12 set over clear", byteDone, 1);
    doKill();

    finishRun();
  end

endmodule